// File: doc/BRIEF.md
# TFT Column Driver Digital Front End

This block is the digital half of a six-output column driver for a TFT panel. A start pulse loads a one-hot sampling token at channel 1. Each accepted pixel beat on the 6-bit colour bus (2 bits each of red, green and blue) is written into the first-rank latch of the channel that holds the token. After that the token moves to the next channel. When channel 6 has taken its value, a one-cycle cascade pulse goes out so that the next driver in a chain can begin sampling.

A rising edge on the line clock copies all of the first rank into the second rank in a single cycle. While the line clock is high (the load phase), every output is held at high impedance. From the second rank and the polarity input, the block builds for each channel a 3-bit tap select for the resistor-string DAC. It applies dot inversion, so neighbouring outputs always have opposite polarity.

The colour bus is a valid/ready stream. A beat is accepted on a clock edge where `pix_valid` and `pix_ready` are both high and `dio_in` is low. `pix_ready` is high only while a token is in flight. The source may hold `pix_valid` low for any number of cycles, and the token waits. The block never drops a beat that it has acknowledged.

Top module: `coldrv_front`

## Requirements
- R1: Synchronous active-high `rst` clears the token, both latch ranks and the transfer history. After reset, `pix_ready`=0, `dio_out`=0, `out_en`=0, and every channel's level field is 0.
- R2: `dio_in` high at a clock edge places the token on channel 1. `pix_ready` is then high until channel 6 has accepted its beat.
- R3: `dio_in` high while a token is in flight restarts sampling from channel 1. No beat is accepted on that edge.
- R4: Channel k (1..6) captures a field on the accepting edge where it holds the token. Channels 1 and 4 take red `pix_data[1:0]`, channels 2 and 5 take green `pix_data[3:2]`, and channels 3 and 6 take blue `pix_data[5:4]`. With `pix_valid` low, the token holds.
- R5: `dio_out` is high for exactly one cycle, in the cycle after channel 6 accepts its beat.
- R6: On each rising edge of `line_clk`, all six second-rank values are loaded from the first rank. The first rank may be refilled later without changing `dac_sel` until the next rising edge.
- R7: `out_en` is all zeros while `line_clk` is high, and all zeros before the first transfer. Otherwise it is all ones.
- R8: Channel k's `dac_sel[3k-1:3k-3]` is {p, level}. Odd-numbered channels have p=`pol` and even-numbered channels have p=~`pol`. p=1 selects the upper (positive) range, and level 0 is the lowest tap of each range. A change of `pol` takes effect at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| dio_in | input | 1 | Start pulse, loads the token at channel 1 |
| pix_data | input | 6 | Colour fields {blue, green, red}, 2 bits each |
| pix_valid | input | 1 | Colour beat present |
| pix_ready | output | 1 | Token in flight, beat can be accepted |
| dio_out | output | 1 | Cascade pulse to the next driver |
| line_clk | input | 1 | Line clock; rising edge transfers, high level is load phase |
| pol | input | 1 | Frame polarity for dot inversion |
| dac_sel | output | 18 | Per-channel tap select {polarity, level}, channel 1 in bits 2:0 |
| out_en | output | 6 | Per-channel output drive enable, 0 means high impedance |

## Verification
The assertions take three things for granted. `line_clk` stays high for at least one `clk` cycle, so that its rising edge is sampled. `dio_in` is a clean synchronous pulse. `pol` changes only at times when its effect on `dac_sel` may be seen directly. The stimulus drives every input half a cycle away from the sampling edge. It holds `line_clk` high for whole cycles, and it raises `dio_in` only with `pix_valid` low or as a deliberate mid-line restart. Back-pressure is exercised by inserting idle cycles with `pix_valid` low in the middle of a line.

// File: rtl/coldrv_pkg.sv
package coldrv_pkg;

  typedef enum logic {
    RANGE_LOW  = 1'b0,
    RANGE_HIGH = 1'b1
  } range_e;

  // Dot inversion: zero-based even index (odd-numbered output) follows pol.
  function automatic range_e range_for(input int idx, input logic pol);
    return range_e'((idx % 2 == 0) ? pol : ~pol);
  endfunction

endpackage

// File: rtl/coldrv_sampler.sv
module coldrv_sampler #(
  parameter int NCH   = 6,
  parameter int LVL_W = 2,
  parameter int NCOL  = 3,
  localparam int BUS_W = NCOL * LVL_W,
  localparam int RANK_W = NCH * LVL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [BUS_W-1:0]  bus,
  input  logic              valid,
  output logic              ready,
  output logic              cascade,
  output logic [RANK_W-1:0] rank1
);

  logic [NCH-1:0] tok;
  logic           accept;

  assign ready  = |tok;
  assign accept = valid & ready & ~start;

  always_ff @(posedge clk) begin
    if (rst) begin
      tok     <= '0;
      cascade <= 1'b0;
    end else begin
      cascade <= accept & tok[NCH-1];
      if (start)       tok <= NCH'(1);
      else if (accept) tok <= tok << 1;
    end
  end

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    localparam int COL = k % NCOL;
    always_ff @(posedge clk) begin
      if (rst)                  rank1[k*LVL_W +: LVL_W] <= '0;
      else if (accept & tok[k]) rank1[k*LVL_W +: LVL_W] <= bus[COL*LVL_W +: LVL_W];
    end
  end

  AST_TOKEN_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(tok)); // R2
  AST_START_LOADS: assert property (@(posedge clk) disable iff (rst)
    start |=> (tok == NCH'(1))); // R3
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!start && !valid) |=> $stable(tok)); // R4
  AST_CASCADE_PULSE: assert property (@(posedge clk) disable iff (rst)
    cascade |=> !cascade); // R5

endmodule

// File: rtl/coldrv_line_latch.sv
module coldrv_line_latch #(
  parameter int NCH   = 6,
  parameter int LVL_W = 2,
  localparam int RANK_W = NCH * LVL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_clk,
  input  logic [RANK_W-1:0] rank1,
  output logic [RANK_W-1:0] rank2,
  output logic [NCH-1:0]    oe
);

  logic line_q;
  logic loaded;
  logic xfer;

  assign xfer = line_clk & ~line_q;
  assign oe   = {NCH{loaded & ~line_clk}};

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= 1'b0;
      loaded <= 1'b0;
      rank2  <= '0;
    end else begin
      line_q <= line_clk;
      if (xfer) begin
        rank2  <= rank1;
        loaded <= 1'b1;
      end
    end
  end

  AST_XFER_COPY: assert property (@(posedge clk) disable iff (rst)
    xfer |=> (rank2 == $past(rank1))); // R6
  AST_RANK2_HOLD: assert property (@(posedge clk) disable iff (rst)
    !xfer |=> $stable(rank2)); // R6
  AST_HIZ_AFTER_EDGE: assert property (@(posedge clk) disable iff (rst)
    (line_clk && line_q) |-> (oe == '0)); // R7

endmodule

// File: rtl/coldrv_polsel.sv
module coldrv_polsel #(
  parameter int NCH   = 6,
  parameter int LVL_W = 2,
  localparam int RANK_W = NCH * LVL_W,
  localparam int SEL_W  = LVL_W + 1
) (
  input  logic                  pol,
  input  logic [RANK_W-1:0]     rank2,
  output logic [NCH*SEL_W-1:0]  sel
);
  import coldrv_pkg::*;

  for (genvar k = 0; k < NCH; k++) begin : g_sel
    range_e rng;
    assign rng = range_for(k, pol);
    assign sel[k*SEL_W +: SEL_W] = {rng, rank2[k*LVL_W +: LVL_W]};
  end

  for (genvar k = 0; k + 1 < NCH; k++) begin : g_chk
    always_comb begin
      AST_NEIGHBOUR_OPPOSE: assert (sel[k*SEL_W + LVL_W] != sel[(k+1)*SEL_W + LVL_W]); // R8
    end
  end

endmodule

// File: rtl/coldrv_front.sv
module coldrv_front #(
  parameter int NCH   = 6,
  parameter int LVL_W = 2,
  parameter int NCOL  = 3,
  localparam int BUS_W = NCOL * LVL_W,
  localparam int SEL_W = LVL_W + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 dio_in,
  input  logic [BUS_W-1:0]     pix_data,
  input  logic                 pix_valid,
  output logic                 pix_ready,
  output logic                 dio_out,
  input  logic                 line_clk,
  input  logic                 pol,
  output logic [NCH*SEL_W-1:0] dac_sel,
  output logic [NCH-1:0]       out_en
);

  logic [NCH*LVL_W-1:0] rank1;
  logic [NCH*LVL_W-1:0] rank2;

  coldrv_sampler #(.NCH(NCH), .LVL_W(LVL_W), .NCOL(NCOL)) u_samp (
    .clk(clk), .rst(rst), .start(dio_in), .bus(pix_data), .valid(pix_valid),
    .ready(pix_ready), .cascade(dio_out), .rank1(rank1)
  );

  coldrv_line_latch #(.NCH(NCH), .LVL_W(LVL_W)) u_line (
    .clk(clk), .rst(rst), .line_clk(line_clk), .rank1(rank1),
    .rank2(rank2), .oe(out_en)
  );

  coldrv_polsel #(.NCH(NCH), .LVL_W(LVL_W)) u_pol (
    .pol(pol), .rank2(rank2), .sel(dac_sel)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!pix_ready && !dio_out && out_en == '0)); // R1

endmodule

// File: tb/sim_coldrv_front.sv
module sim_coldrv_front;
  localparam int CLK_P = 10;
  localparam int NCH = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dio_in = 1'b0;
  logic [5:0] pix_data = '0;
  logic pix_valid = 1'b0;
  logic pix_ready, dio_out;
  logic line_clk = 1'b0;
  logic pol = 1'b0;
  logic [17:0] dac_sel;
  logic [5:0] out_en;

  int checks = 0;
  int errors = 0;
  int exp_lvl [NCH];
  int shown_lvl [NCH];

  always #(CLK_P/2) clk = ~clk;

  coldrv_front u0 (
    .clk(clk), .rst(rst), .dio_in(dio_in), .pix_data(pix_data),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .dio_out(dio_out),
    .line_clk(line_clk), .pol(pol), .dac_sel(dac_sel), .out_en(out_en)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int sel_exp(input int i, input int lvl, input bit p);
    int pb = (p ^ (i % 2)) & 1;
    return pb * 4 + lvl;
  endfunction

  task automatic chk_sel(input string req);
    for (int i = 0; i < NCH; i++) begin
      int act = int'(dac_sel[i*3 +: 3]);
      int exp = sel_exp(i, shown_lvl[i], pol);
      chk(act == exp, req, act, exp);
    end
  endtask

  // Beat b of a line with offset base: R=(base+b)%4, G=(base+b+1)%4, B=(base+b+2)%4
  task automatic send_line(input int base, input int gap_at, input int gap_len);
    dio_in = 1'b1;
    step();
    dio_in = 1'b0;
    chk(pix_ready == 1'b1, "R2 ready after start", int'(pix_ready), 1);
    for (int b = 0; b < NCH; b++) begin
      if (b == gap_at) begin
        pix_valid = 1'b0;
        for (int g = 0; g < gap_len; g++) step();
        chk(pix_ready == 1'b1 && dio_out == 1'b0, "R4 stall holds token", int'(pix_ready), 1);
      end
      pix_data  = {2'((base+b+2)%4), 2'((base+b+1)%4), 2'((base+b)%4)};
      pix_valid = 1'b1;
      step();
      if (b < NCH-1)
        chk(pix_ready == 1'b1 && dio_out == 1'b0, "R2 token mid line", int'(dio_out), 0);
      else begin
        chk(dio_out == 1'b1, "R5 cascade after channel 6", int'(dio_out), 1);
        chk(pix_ready == 1'b0, "R2 ready drops at end", int'(pix_ready), 0);
      end
    end
    pix_valid = 1'b0;
    step();
    chk(dio_out == 1'b0, "R5 cascade single cycle", int'(dio_out), 0);
    for (int i = 0; i < NCH; i++) exp_lvl[i] = (base + i + (i % 3)) % 4;
  endtask

  task automatic do_transfer();
    line_clk = 1'b1;
    step();
    chk(out_en == 6'd0, "R7 hiz during load", int'(out_en), 0);
    for (int i = 0; i < NCH; i++) shown_lvl[i] = exp_lvl[i];
    chk_sel("R6 R4 transfer values");
    line_clk = 1'b0;
    step();
    chk(out_en == 6'h3F, "R7 drive after load", int'(out_en), 63);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    step(); step();
    rst = 1'b0;
    step();
    chk(pix_ready == 1'b0, "R1 ready", int'(pix_ready), 0);
    chk(dio_out == 1'b0, "R1 cascade", int'(dio_out), 0);
    chk(out_en == 6'd0, "R1 out_en", int'(out_en), 0);
    for (int i = 0; i < NCH; i++) shown_lvl[i] = 0;
    chk_sel("R1 R8 reset select");
  endtask

  task automatic t_first_line();
    send_line(0, -1, 0);
    chk(out_en == 6'd0, "R7 no drive before first transfer", int'(out_en), 0);
    chk_sel("R6 rank2 untouched before transfer");
    do_transfer();
  endtask

  task automatic t_isolate();
    send_line(1, -1, 0);
    chk_sel("R6 refill does not reach outputs");
    chk(out_en == 6'h3F, "R7 still driving", int'(out_en), 63);
    do_transfer();
  endtask

  task automatic t_backpressure();
    send_line(3, 2, 3);
    do_transfer();
  endtask

  task automatic t_restart();
    dio_in = 1'b1;
    step();
    dio_in = 1'b0;
    for (int b = 0; b < 3; b++) begin
      pix_data = 6'b111111;
      pix_valid = 1'b1;
      step();
    end
    pix_valid = 1'b1;
    dio_in = 1'b1;
    step();
    dio_in = 1'b0;
    pix_valid = 1'b0;
    chk(pix_ready == 1'b1 && dio_out == 1'b0, "R3 restart keeps ready", int'(pix_ready), 1);
    pix_valid = 1'b0;
    send_line(2, -1, 0);
    do_transfer();
  endtask

  task automatic t_pol();
    pol = 1'b1;
    #1;
    chk_sel("R8 pol high");
    pol = 1'b0;
    #1;
    chk_sel("R8 pol low");
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_first_line();
    t_pol();
    t_isolate();
    t_backpressure();
    t_restart();
    t_pol();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule